// File: doc/BRIEF.md
# Split-Section Decade Counter with Zero and Nine Presets

This block is a synchronous model of a four-bit ripple counter made of two separately driven sections. The lower section is a single toggle bit. The upper section is a three-bit counter that cycles through five states by default. Each section has its own count input. A section advances when its count input goes from high to low, as sampled on the single system clock. Because each section is driven on its own, the user chooses the count order by wiring outside the block.

Wiring the lower bit into the upper section's count input gives a BCD decade count, 0 through 9. Wiring the top output bit back into the lower section's count input gives a divide-by-ten square wave on the lower bit, high for five input pulses and low for five.

Two gated overrides act on the next system clock edge, ahead of any count. The first, which needs both of its inputs high, forces the value to zero. The second, which also needs both of its inputs high, forces the value to nine, for nine's-complement use. A parameter selects an upper-section cycle length of five, six or eight.

Top module: `decade_pair_counter`

## Requirements
- R1: While rstN is low, qOut is 0000.
- R2: The count inputs are sampled on each rising edge of clk. When the sample at an edge is 0 and the sample at the edge before was 1, that section advances at that same edge. The lower section toggles qOut[0].
- R3: A rising transition on a count input, or a level held high or low, leaves qOut unchanged.
- R4: The upper section drives qOut[3:1] as a binary count with qOut[1] as the least significant bit. With UPPER_MOD=5 it steps 0,1,2,3,4 and then wraps to 0.
- R5: With cntHigh fed from qOut[0] and pulses applied on cntLow, qOut reads 0,1,...,9 and then returns to 0.
- R6: With cntLow fed from qOut[3] and pulses applied on cntHigh, qOut[0] is high for 5 consecutive input pulses and low for the next 5.
- R7: When clrA and clrB are both high, qOut becomes 0000 at the next clk edge, even if a count edge arrives in that cycle. When only one of them is high, it has no effect.
- R8: When nineA and nineB are both high, qOut becomes 1001 (qOut[3]=1, qOut[0]=1) at the next clk edge. When only one of them is high, it has no effect.
- R9: When both gated overrides are active together, the result is 1001.
- R10: With UPPER_MOD=8 the upper section steps 0 through 7 and then wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and state changes happen on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset of all state |
| cntLow | input | 1 | Count input of the toggle section |
| cntHigh | input | 1 | Count input of the upper section |
| clrA | input | 1 | First input of the clear-to-zero gate |
| clrB | input | 1 | Second input of the clear-to-zero gate |
| nineA | input | 1 | First input of the preset-to-nine gate |
| nineB | input | 1 | Second input of the preset-to-nine gate |
| qOut | output | 4 | Count value; bit 0 is the toggle section, bits 3:1 are the upper section |

## Verification
The hardest case to reach from the ports is a clear that arrives in the same cycle as a genuine count edge. To produce it, the stimulus first raises a count input and lets it settle. It then drops that input on the same clock step in which both clear inputs go high, so that the edge detector and the clear gate fire together. The symmetrical order is also hard to reach, because the lower section is then driven only by the design's own top bit. The bench therefore switches the external wiring into that feedback form and tracks twenty upper-section pulses through two full square-wave periods.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef struct packed {
    logic clear;
    logic preset;
    logic advLow;
    logic advHigh;
  } dpc_strobe_t;
  localparam int NINE_UPPER = 4;
endpackage

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cntLow,
  input  logic        cntHigh,
  input  logic        clrA,
  input  logic        clrB,
  input  logic        nineA,
  input  logic        nineB,
  output dpc_strobe_t stb
);
  logic prevLow;
  logic prevHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLow  <= 1'b0;
      prevHigh <= 1'b0;
    end else begin
      prevLow  <= cntLow;
      prevHigh <= cntHigh;
    end
  end

  always_comb begin
    stb.clear   = clrA & clrB;
    stb.preset  = nineA & nineB;
    stb.advLow  = prevLow & ~cntLow;
    stb.advHigh = prevHigh & ~cntHigh;
  end

  // A falling edge can be reported for only one cycle in a row.
  assert_single_adv_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.advLow |=> !stb.advLow);
  assert_single_adv_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.advHigh |=> !stb.advHigh);
endmodule

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
#(
  parameter int UPPER_MOD = 5,
  parameter int UPPER_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpc_strobe_t        stb,
  output logic               lowBit,
  output logic [UPPER_W-1:0] upperCnt
);
  localparam logic [UPPER_W-1:0] UpperMax  = UPPER_W'(UPPER_MOD - 1);
  localparam logic [UPPER_W-1:0] UpperNine = UPPER_W'(NINE_UPPER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowBit   <= 1'b0;
      upperCnt <= '0;
    end else if (stb.preset) begin
      lowBit   <= 1'b1;
      upperCnt <= UpperNine;
    end else if (stb.clear) begin
      lowBit   <= 1'b0;
      upperCnt <= '0;
    end else begin
      if (stb.advLow) lowBit <= ~lowBit;
      if (stb.advHigh) upperCnt <= (upperCnt == UpperMax) ? '0 : upperCnt + 1'b1;
    end
  end

  assert_upper_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    upperCnt <= UpperMax);
  assert_upper_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advHigh && !stb.clear && !stb.preset && upperCnt == UpperMax) |=> upperCnt == '0);
  assert_low_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advLow && !stb.clear && !stb.preset) |=> lowBit != $past(lowBit));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.advHigh && !stb.advLow && !stb.clear && !stb.preset) |=>
      ($stable(upperCnt) && $stable(lowBit)));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clear && !stb.preset) |=> (!lowBit && upperCnt == '0));
  assert_preset_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.preset && !stb.clear) |=> (lowBit && upperCnt == UpperNine));
  assert_preset_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.preset && stb.clear) |=> (lowBit && upperCnt == UpperNine));
endmodule

// File: rtl/decade_pair_counter.sv
module decade_pair_counter
  import dpc_pkg::*;
#(
  parameter int UPPER_MOD = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntLow,
  input  logic       cntHigh,
  input  logic       clrA,
  input  logic       clrB,
  input  logic       nineA,
  input  logic       nineB,
  output logic [3:0] qOut
);
  localparam int UpperW = 3;

  dpc_strobe_t       stb;
  logic              lowBit;
  logic [UpperW-1:0] upperCnt;

  dpc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cntLow(cntLow), .cntHigh(cntHigh),
    .clrA(clrA), .clrB(clrB), .nineA(nineA), .nineB(nineB), .stb(stb)
  );

  dpc_datapath #(.UPPER_MOD(UPPER_MOD), .UPPER_W(UpperW)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .lowBit(lowBit), .upperCnt(upperCnt)
  );

  assign qOut = {upperCnt, lowBit};
endmodule

// File: tb/decade_pair_counter_bench.sv
module decade_pair_counter_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, drvLow, drvHigh, clrA, clrB, nineA, nineB, m8High;
  int   mode;
  logic cntLowIn, cntHighIn;
  logic [3:0] q, q8;

  assign cntLowIn  = (mode == 2) ? q[3] : drvLow;
  assign cntHighIn = (mode == 1) ? q[0] : drvHigh;

  decade_pair_counter u_decade_pair_counter (
    .clk(clk), .rstN(rstN), .cntLow(cntLowIn), .cntHigh(cntHighIn),
    .clrA(clrA), .clrB(clrB), .nineA(nineA), .nineB(nineB), .qOut(q)
  );

  decade_pair_counter #(.UPPER_MOD(8)) u_decade_pair_counter_mod8 (
    .clk(clk), .rstN(rstN), .cntLow(1'b0), .cntHigh(m8High),
    .clrA(1'b0), .clrB(1'b0), .nineA(1'b0), .nineB(1'b0), .qOut(q8)
  );

  typedef struct { logic [3:0] val; int dut; string tag; } exp_t;
  exp_t expQ[$];
  int checks = 0;
  int errors = 0;
  int lowRef = 0;
  int upRef  = 0;
  int m8Ref  = 0;
  int highCount;

  always @(negedge clk) begin
    exp_t e;
    logic [3:0] act;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      act = (e.dut == 1) ? q8 : q;
      checks++;
      if (act !== e.val) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", e.tag, act, e.val);
      end
    end
  end

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectVal(input logic [3:0] v, input int dut, input string tag);
    expQ.push_back('{v, dut, tag});
    @(negedge clk);
    waitc(1);
  endtask

  function automatic logic [3:0] refVal();
    return {upRef[2:0], lowRef[0]};
  endfunction

  task automatic pulseLow();
    drvLow = 1'b1; waitc(3); drvLow = 1'b0; waitc(3);
  endtask

  task automatic pulseHigh();
    drvHigh = 1'b1; waitc(3); drvHigh = 1'b0; waitc(3);
  endtask

  task automatic clearAll();
    clrA = 1'b1; clrB = 1'b1; waitc(2); clrA = 1'b0; clrB = 1'b0; waitc(1);
    lowRef = 0; upRef = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; drvLow = 0; drvHigh = 0; clrA = 0; clrB = 0;
    nineA = 0; nineB = 0; m8High = 0; mode = 0;
    waitc(3);
    expectVal(4'b0000, 0, "R1 reset main");
    expectVal(4'b0000, 1, "R1 reset mod8");
    rstN = 1'b1; waitc(2);

    // R2 lower toggle
    pulseLow(); lowRef = 1; expectVal(refVal(), 0, "R2 toggle up");
    pulseLow(); lowRef = 0; expectVal(refVal(), 0, "R2 toggle down");

    // R3 rising edges and held levels
    drvLow = 1'b1; waitc(3); expectVal(refVal(), 0, "R3 low rise ignored");
    drvLow = 1'b0; waitc(3); lowRef = 1; expectVal(refVal(), 0, "R2 fall after hold");
    drvHigh = 1'b1; waitc(3); expectVal(refVal(), 0, "R3 high rise ignored");
    drvHigh = 1'b0; waitc(3); upRef = 1; expectVal(refVal(), 0, "R4 first upper step");

    // R4 upper sequence with wrap
    for (int i = 0; i < 5; i++) begin
      pulseHigh(); upRef = (upRef + 1) % 5;
      expectVal(refVal(), 0, "R4 upper step");
    end

    // R7 clear overriding a count edge in the same cycle
    drvLow = 1'b1; waitc(3);
    clrA = 1'b1; clrB = 1'b1; drvLow = 1'b0; waitc(2);
    clrA = 1'b0; clrB = 1'b0; lowRef = 0; upRef = 0;
    expectVal(4'b0000, 0, "R7 clear beats count");
    clrA = 1'b1; pulseLow(); lowRef = 1;
    expectVal(refVal(), 0, "R7 single clear ignored");
    clrA = 1'b0;

    // R8 preset
    nineB = 1'b1; waitc(3); expectVal(refVal(), 0, "R8 single preset ignored");
    nineA = 1'b1; waitc(2); nineA = 1'b0; nineB = 1'b0;
    expectVal(4'b1001, 0, "R8 preset to nine");

    // R9 priority
    clearAll(); expectVal(4'b0000, 0, "R7 clear from nine");
    clrA = 1; clrB = 1; nineA = 1; nineB = 1; waitc(2);
    clrA = 0; clrB = 0; nineA = 0; nineB = 0;
    expectVal(4'b1001, 0, "R9 preset wins");

    // R5 BCD order
    clearAll(); mode = 1; waitc(2);
    for (int d = 1; d <= 12; d++) begin
      pulseLow();
      expectVal(4'(d % 10), 0, "R5 BCD count");
    end

    // R6 symmetrical divide-by-ten
    mode = 0; clearAll(); mode = 2; waitc(2);
    highCount = 0;
    for (int i = 1; i <= 20; i++) begin
      pulseHigh();
      if (upRef == 4) begin upRef = 0; lowRef ^= 1; end
      else upRef++;
      expectVal(refVal(), 0, "R6 symmetric step");
      if (i > 5 && i <= 15 && q[0]) highCount++;
    end
    checks++;
    if (highCount != 5) begin
      errors++;
      $display("FAIL R6 duty actual=%0d expected=5", highCount);
    end
    mode = 0;

    // R10 divide-by-eight variant
    for (int i = 0; i < 9; i++) begin
      m8High = 1'b1; waitc(3); m8High = 1'b0; waitc(3);
      m8Ref = (m8Ref + 1) % 8;
      expectVal({m8Ref[2:0], 1'b0}, 1, "R10 mod8 step");
    end

    waitc(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule